// File: doc/BRIEF.md
# Duplicated Byte-Substitution Layer with Lane Mismatch Detection

This block performs the non-linear byte-substitution step of a 128-bit block cipher round and checks its own result. It holds two complete and independent substitution layers. Both are fed the same sixteen-byte state in the same direction, forward or inverse. Their results are compared byte by byte. The result of the first copy goes out as the substituted state. Each byte lane whose two results differ sets one bit of a mismatch vector, and the OR of that vector drives a fault flag. A downstream sticky error latch is expected to capture that flag. The non-linear step cannot be covered by parity prediction, so duplication is the check used here.

Each byte substitution works in GF(2^8) with the reduction polynomial x^8+x^4+x^3+x+1. In the forward direction the unit takes the field inverse, with zero mapped to zero, and then applies an affine map with the constant 0x63. In the inverse direction it first undoes that affine map and then takes the field inverse. A test pattern input is XORed into the second copy's result before the comparison. With it, a bench or a production test can prove that every lane's comparator responds. The state, the mismatch vector and the flag are registered together, one clock after the inputs.

Top module: `sbox_dup_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registered outputs `state_out`, `mismatch` and `fault` are all cleared to zero at that edge.
- R2: With `inv_mode` = 0, each output byte equals the forward substitution of the input byte. The forward substitution is the GF(2^8) inverse modulo 0x11B (0x00 maps to 0x00), followed by the affine map out_i = b_i ^ b_(i+4 mod 8) ^ b_(i+5 mod 8) ^ b_(i+6 mod 8) ^ b_(i+7 mod 8) ^ bit i of 0x63. For example 0x00 becomes 0x63 and 0x53 becomes 0xED.
- R3: With `inv_mode` = 1, each output byte is the inverse substitution of the input byte: the inverse affine map, then the field inverse. It is the exact inverse of R2, so 0x63 becomes 0x00 and 0xED becomes 0x53.
- R4: Byte lane k occupies bits [8k+7:8k] of `state_in`, `state_out` and `inject_pat`, and bit k of `mismatch`. Each lane is substituted independently of the other lanes.
- R5: `state_out`, `mismatch` and `fault` show the result for the inputs that were present at the previous rising clock edge, one cycle of latency.
- R6: When `inject_pat` is all zero, `mismatch` and `fault` stay zero for every input state in both directions.
- R7: `mismatch[k]` is set exactly when byte lane k of `inject_pat` is nonzero. A pattern in one lane flags no other lane.
- R8: `fault` is high exactly when at least one bit of `mismatch` is high, in the same cycle.
- R9: `state_out` always comes from the first copy, so a nonzero `inject_pat` never changes the substituted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_mode | input | 1 | 0 selects forward substitution, 1 selects inverse; shared by both copies |
| state_in | input | 128 | Input state, lane k in bits [8k+7:8k] |
| inject_pat | input | 128 | Test pattern XORed into the second copy's result before comparison |
| state_out | output | 128 | Registered substituted state from the first copy |
| mismatch | output | 16 | Registered per-lane disagreement vector |
| fault | output | 1 | Registered OR of the mismatch vector |

## Verification
The bench sweeps every byte value through every lane in both directions and compares the result against tables it builds from logarithms to base 3. A wrong reduction constant, a rotated affine tap or a swapped order of operations in the inverse path would corrupt most of those 512 vectors. It would also break the fixed points 0x00/0x63 and 0x53/0xED. Single-bit patterns are then injected into each of the 128 bit positions. A comparator that misses a bit, reports the wrong lane, ORs the lanes incorrectly or takes its output from the tampered copy would give a wrong mismatch vector or a changed state. A reset applied in the middle of a run with live inputs catches outputs that are left out of the reset.

// File: rtl/sbox_dup_pkg.sv
// Package sbox_dup_pkg
// Shared constants, the direction type and the GF(2^8) arithmetic used by
// every substitution unit. All functions are pure combinational logic.
// Assumes byte-wide lanes and the field polynomial x^8+x^4+x^3+x+1.
package sbox_dup_pkg;

    localparam int          LANE_W      = 8;
    localparam logic [7:0]  FIELD_RED   = 8'h1B;  // low byte of 0x11B
    localparam logic [7:0]  FWD_CONST   = 8'h63;
    localparam logic [7:0]  INV_CONST   = 8'h05;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } sub_dir_e;

    // Multiply by x in the field
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? FIELD_RED : 8'h00);
    endfunction

    // General field product by shift-and-add
    function automatic logic [7:0] gf_prod(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] run;
        acc = 8'h00;
        run = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ run;
            run = gf_dbl(run);
        end
        return acc;
    endfunction

    // Field inverse as a^254; zero maps to zero without a special case
    function automatic logic [7:0] gf_recip(input logic [7:0] a);
        logic [7:0] acc;
        logic [7:0] sq;
        acc = 8'h01;
        sq  = a;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_prod(sq, sq);
            acc = gf_prod(acc, sq);
        end
        return acc;
    endfunction

    // Forward affine map over GF(2)
    function automatic logic [7:0] fwd_affine(input logic [7:0] a);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) begin
            o[i] = a[i] ^ a[(i + 4) % 8] ^ a[(i + 5) % 8]
                 ^ a[(i + 6) % 8] ^ a[(i + 7) % 8] ^ FWD_CONST[i];
        end
        return o;
    endfunction

    // Inverse of fwd_affine
    function automatic logic [7:0] inv_affine(input logic [7:0] a);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) begin
            o[i] = a[(i + 2) % 8] ^ a[(i + 5) % 8] ^ a[(i + 7) % 8] ^ INV_CONST[i];
        end
        return o;
    endfunction

endpackage

// File: rtl/sub_byte_unit.sv
// Module sub_byte_unit
// One byte substitution in either direction. A single field inverter is
// shared: the inverse affine map is placed in front of it when the
// direction is inverse, and the forward affine map after it otherwise.
// Purely combinational; assumes dir is stable for the evaluation.
module sub_byte_unit
    import sbox_dup_pkg::*;
(
    input  sub_dir_e    dir,
    input  logic [7:0]  byte_in,
    output logic [7:0]  byte_out
);

    logic [7:0] pre_inv;
    logic [7:0] post_inv;

    // Select the inverter operand, invert, then select the final map
    always_comb begin
        pre_inv  = (dir == DIR_INV) ? inv_affine(byte_in) : byte_in;
        post_inv = gf_recip(pre_inv);
        byte_out = (dir == DIR_INV) ? post_inv : fwd_affine(post_inv);
    end

endmodule

// File: rtl/sub_layer.sv
// Module sub_layer
// A full substitution layer: NUM_LANES independent byte units, lane k on
// bits [8k+7:8k]. Combinational; all lanes share one direction.
module sub_layer
    import sbox_dup_pkg::*;
#(
    parameter  int NUM_LANES = 16,
    localparam int STATE_W   = NUM_LANES * LANE_W
) (
    input  sub_dir_e             dir,
    input  logic [STATE_W-1:0]   layer_in,
    output logic [STATE_W-1:0]   layer_out
);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        sub_byte_unit u_unit (
            .dir      (dir),
            .byte_in  (layer_in [k*LANE_W +: LANE_W]),
            .byte_out (layer_out[k*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/lane_compare.sv
// Module lane_compare
// Byte-wise equality between two states; bit k is high when lane k of the
// two inputs differs. Combinational.
module lane_compare
    import sbox_dup_pkg::*;
#(
    parameter  int NUM_LANES = 16,
    localparam int STATE_W   = NUM_LANES * LANE_W
) (
    input  logic [STATE_W-1:0]   side_a,
    input  logic [STATE_W-1:0]   side_b,
    output logic [NUM_LANES-1:0] differs
);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_cmp
        assign differs[k] = (side_a[k*LANE_W +: LANE_W] != side_b[k*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/sbox_dup_guard.sv
// Module sbox_dup_guard (top)
// Two independent substitution layers evaluate the same state in the same
// direction. The second copy's result is XORed with inject_pat (all zero in
// normal use) and compared lane by lane with the first. The first copy's
// result, the lane mismatch vector and its OR are registered together.
// Assumes: synchronous active-low reset; fault is latched downstream.
module sbox_dup_guard
    import sbox_dup_pkg::*;
#(
    parameter  int NUM_LANES = 16,
    localparam int STATE_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inv_mode,
    input  logic [STATE_W-1:0]   state_in,
    input  logic [STATE_W-1:0]   inject_pat,
    output logic [STATE_W-1:0]   state_out,
    output logic [NUM_LANES-1:0] mismatch,
    output logic                 fault
);

    sub_dir_e               dir;
    logic [STATE_W-1:0]     res_a;
    logic [STATE_W-1:0]     res_b;
    logic [STATE_W-1:0]     res_b_seen;
    logic [NUM_LANES-1:0]   lane_diff;

    assign dir        = sub_dir_e'(inv_mode);
    assign res_b_seen = res_b ^ inject_pat;

    sub_layer #(.NUM_LANES(NUM_LANES)) u_copy_a (
        .dir       (dir),
        .layer_in  (state_in),
        .layer_out (res_a)
    );

    sub_layer #(.NUM_LANES(NUM_LANES)) u_copy_b (
        .dir       (dir),
        .layer_in  (state_in),
        .layer_out (res_b)
    );

    lane_compare #(.NUM_LANES(NUM_LANES)) u_cmp (
        .side_a  (res_a),
        .side_b  (res_b_seen),
        .differs (lane_diff)
    );

    // Output stage: capture state, lane vector and flag in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_out <= '0;
            mismatch  <= '0;
            fault     <= 1'b0;
        end else begin
            state_out <= res_a;
            mismatch  <= lane_diff;
            fault     <= |lane_diff;
        end
    end

endmodule

// File: rtl/sbox_dup_guard_chk.sv
// Module sbox_dup_guard_chk
// Property checker for sbox_dup_guard, attached by bind below. Observes
// only the top-level ports.
module sbox_dup_guard_chk #(
    parameter  int NUM_LANES = 16,
    localparam int STATE_W   = NUM_LANES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inv_mode,
    input  logic [STATE_W-1:0]   state_in,
    input  logic [STATE_W-1:0]   inject_pat,
    input  logic [STATE_W-1:0]   state_out,
    input  logic [NUM_LANES-1:0] mismatch,
    input  logic                 fault
);

    // R1: a reset edge clears every registered output
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (state_out == '0 && mismatch == '0 && !fault));

    // R6: no pattern, no disagreement
    p_clean_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inject_pat == '0) |=> (mismatch == '0 && !fault));

    // R8: flag follows the vector
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch != '0) |-> fault);
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch == '0) |-> !fault);

    // R7: each lane responds to its own pattern byte and only to it
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane_chk
        p_lane_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (inject_pat[k*8 +: 8] != 8'h00) |=> mismatch[k]);
        p_lane_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (inject_pat[k*8 +: 8] == 8'h00) |=> !mismatch[k]);
    end

endmodule

bind sbox_dup_guard sbox_dup_guard_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_mode   (inv_mode),
    .state_in   (state_in),
    .inject_pat (inject_pat),
    .state_out  (state_out),
    .mismatch   (mismatch),
    .fault      (fault)
);

// File: tb/test_sbox_dup_guard.sv
// Bench for sbox_dup_guard: exhaustive per-lane sweeps in both directions
// against tables built from base-3 logarithms, and per-bit pattern injection.
module test_sbox_dup_guard;

    localparam int LANES = 16;
    localparam int SW    = LANES * 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            inv_mode;
    logic [SW-1:0]   state_in;
    logic [SW-1:0]   inject_pat;
    logic [SW-1:0]   state_out;
    logic [LANES-1:0] mismatch;
    logic            fault;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp3 [256];
    logic [7:0] log3 [256];
    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    always #2 clk = ~clk;   // 250 MHz

    sbox_dup_guard #(.NUM_LANES(LANES)) i_sbox_dup_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv_mode   (inv_mode),
        .state_in   (state_in),
        .inject_pat (inject_pat),
        .state_out  (state_out),
        .mismatch   (mismatch),
        .fault      (fault)
    );

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // Build log/antilog tables with generator 3, then both substitution tables
    task automatic build_tables();
        logic [7:0] x;
        logic [7:0] r;
        x = 8'h01;
        log3[0] = 8'h00;
        for (int i = 0; i < 255; i++) begin
            exp3[i] = x;
            log3[x] = 8'(i);
            x = x ^ ({x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00));
        end
        for (int v = 0; v < 256; v++) begin
            r = (v == 0) ? 8'h00 : exp3[(255 - int'(log3[v])) % 255];
            fwd_tab[v] = r ^ rotl(r, 1) ^ rotl(r, 2) ^ rotl(r, 3) ^ rotl(r, 4) ^ 8'h63;
        end
        for (int v = 0; v < 256; v++) inv_tab[fwd_tab[v]] = 8'(v);
    endtask

    function automatic logic [SW-1:0] expect_state(input logic [SW-1:0] s, input logic m);
        logic [SW-1:0] o;
        for (int k = 0; k < LANES; k++)
            o[k*8 +: 8] = m ? inv_tab[s[k*8 +: 8]] : fwd_tab[s[k*8 +: 8]];
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then wait one full cycle so the register has captured
    task automatic drive(input logic [SW-1:0] s, input logic m, input logic [SW-1:0] p);
        @(negedge clk);
        state_in = s; inv_mode = m; inject_pat = p;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [SW-1:0] s;
        logic [SW-1:0] e;
        build_tables();
        rst_n = 1'b0; inv_mode = 1'b0; state_in = '1; inject_pat = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(state_out == '0 && mismatch == '0 && !fault, "R1 reset", state_out, '0);
        rst_n = 1'b1;

        // R2 / R3: known values, R5 latency shown by sampling one cycle later
        drive({LANES{8'h00}}, 1'b0, '0);
        check(state_out == {LANES{8'h63}}, "R2 00->63", state_out, {LANES{8'h63}});
        drive({LANES{8'h53}}, 1'b0, '0);
        check(state_out == {LANES{8'hED}}, "R2 53->ED", state_out, {LANES{8'hED}});
        drive({LANES{8'h63}}, 1'b1, '0);
        check(state_out == {LANES{8'h00}}, "R3 63->00", state_out, {LANES{8'h00}});
        drive({LANES{8'hED}}, 1'b1, '0);
        check(state_out == {LANES{8'h53}}, "R3 ED->53", state_out, {LANES{8'h53}});

        // R2 R4 R5 R6: forward sweep, every value in every lane
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 256; v++) begin
                for (int k = 0; k < LANES; k++) s[k*8 +: 8] = 8'(v + 37 * k);
                e = expect_state(s, m[0]);
                drive(s, m[0], '0);
                if (m == 0) check(state_out == e, "R2 R4 forward sweep", state_out, e);
                else        check(state_out == e, "R3 R4 inverse sweep", state_out, e);
                check(mismatch == '0 && !fault, "R6 clean compare", SW'(mismatch), '0);
            end
        end

        // R7 R8 R9: single-bit injection in every bit position
        for (int b = 0; b < SW; b++) begin
            for (int k = 0; k < LANES; k++) s[k*8 +: 8] = 8'(b * 5 + k);
            e = expect_state(s, b[0]);
            drive(s, b[0], SW'(1) << b);
            check(mismatch == LANES'(1) << (b / 8), "R7 lane flag", SW'(mismatch), SW'(LANES'(1) << (b / 8)));
            check(fault, "R8 flag on single lane", SW'(fault), SW'(1));
            check(state_out == e, "R9 output from first copy", state_out, e);
        end

        // R7 R8: two lanes and all lanes
        s = {LANES{8'hA5}};
        drive(s, 1'b0, {8'h80, {(LANES-2){8'h00}}, 8'h01});
        check(mismatch == {1'b1, {(LANES-2){1'b0}}, 1'b1} && fault, "R7 R8 end lanes",
              SW'(mismatch), SW'({1'b1, {(LANES-2){1'b0}}, 1'b1}));
        drive(s, 1'b1, '1);
        check(mismatch == '1 && fault, "R7 R8 all lanes", SW'(mismatch), SW'({LANES{1'b1}}));
        check(state_out == expect_state(s, 1'b1), "R9 all lanes tampered", state_out, expect_state(s, 1'b1));

        // R1: reset in the middle of live traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(state_out == '0 && mismatch == '0 && !fault, "R1 mid-run reset", state_out, '0);
        rst_n = 1'b1;
        inject_pat = '0;
        @(negedge clk);
        check(state_out == expect_state(s, 1'b1) && !fault, "R5 R6 after reset", state_out, expect_state(s, 1'b1));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule